// File: doc/BRIEF.md
# Pointer-Indexed FIFO and Mailbox Host Interface

This block is the board-side register window that a host sees across eight byte-wide I/O offsets. Bytes the host writes to the data offset queue in an outbound FIFO that the local processor drains. Bytes the local processor pushes queue in an inbound FIFO that the host drains through the same offset. The control offset serves two purposes. A read returns a status byte. A write loads a selector, and the single access that follows at the control offset reaches the internal register named by that selector.

The internal registers are a command register, an interrupt mask, a byte-compare value, a threshold byte for the almost-empty and almost-full flags, and two single-byte mailboxes, one for each direction. The local processor has a simpler strobe port with its own status view. It also owns the global interrupt enable. A write to offset 7 resets the whole block. With default parameters each FIFO holds 512 bytes.

Top module: `fifo_mbox_bridge`

## Requirements
- R1: After reset the host status byte reads 0xA8 (reset-event bit 7, inbound-empty bit 5, inbound-almost-empty bit 3), the local status reads 0x28, and `h_irq` is low.
- R2: Bytes written at offset 0 leave through `l_rdata`/`l_pop` in write order. Bytes pushed with `l_push` are returned by host reads of offset 0 in push order.
- R3: Outbound-full is status bit 6. A host write at offset 0 while the outbound FIFO is full is dropped. A host read of offset 0 while the inbound FIFO is empty returns 0x00.
- R4: A write at offset 2 with selector code 1..6 makes only the next offset-2 access (read or write) reach the selected register. Later offset-2 reads return status. Codes 0 and 7 select nothing.
- R5: Selector codes are 1 command, 2 interrupt mask, 3 byte-compare, 4 outbound mailbox, 5 threshold, 6 inbound mailbox (read). Mask, byte-compare and threshold read back what was written.
- R6: Status bit 7 (reset event) is set by any reset and is cleared by a host status read.
- R7: The threshold byte holds the almost-full margin in bits 7:4 and the almost-empty level in bits 3:0. Status bit 3 is set while the inbound count is at or below the level. Status bit 4 is set while the outbound count plus the margin is at least the depth.
- R8: A local mailbox write sets status bit 2. A host read through selector 6 returns the byte and clears bit 2.
- R9: A host write through selector 4 fills the outbound mailbox, which is visible on `l_mb_rdata` and sets local status bit 2. After `l_mb_rd` the mailbox reads back as 0x00.
- R10: Status bit 1 is set while the inbound FIFO is non-empty and its head byte equals the byte-compare register.
- R11: Command 0x80 empties both FIFOs and both mailboxes and sets bit 7. Command 0x40 makes host status show the local view (bit 6 inbound full, 5 outbound empty, 4 inbound almost full, 3 outbound almost empty, 2 outbound mailbox full). Command 0x00 restores the normal view. The command reads back as 0x40 while swapped.
- R12: `h_irq` is high only when the global enable is set and either bit 7 is set (it cannot be masked) or some status bit 6..0 has its mask bit set. The local port sets and clears the enable.
- R13: A host write at offset 7 acts as a full reset: it clears the global enable, the mask and the thresholds, and sets bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs | input | 1 | Host access strobe |
| h_wr | input | 1 | Host write |
| h_rd | input | 1 | Host read |
| h_addr | input | 3 | Host offset |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte (combinational) |
| h_irq | output | 1 | Host interrupt |
| l_push | input | 1 | Local push into inbound FIFO |
| l_wdata | input | 8 | Local push byte |
| l_pop | input | 1 | Local pop from outbound FIFO |
| l_rdata | output | 8 | Outbound FIFO head (0 when empty) |
| l_mb_wr | input | 1 | Local write of inbound mailbox |
| l_mb_wdata | input | 8 | Inbound mailbox byte |
| l_mb_rd | input | 1 | Local consume of outbound mailbox |
| l_mb_rdata | output | 8 | Outbound mailbox contents |
| l_gie_wr | input | 1 | Global interrupt enable write strobe |
| l_gie_val | input | 1 | Global interrupt enable value |
| l_status | output | 8 | Local status view |

## Verification
The bench builds the block with `DEPTH_LOG2 = 3`, so each FIFO holds eight bytes. At that depth the outbound FIFO can be filled past capacity within a few cycles, which exercises the dropped ninth write. The almost-full margin of 2 and the almost-empty level of 3 cross their trip points after a handful of pushes, so both edges of each flag are tested. The default depth of 512 uses the same address arithmetic with wider pointers and counters.

// File: rtl/fmb_pkg.sv
package fmb_pkg;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CMD  = 3'd1,
        SEL_MASK = 3'd2,
        SEL_BDET = 3'd3,
        SEL_OMB  = 3'd4,
        SEL_THR  = 3'd5,
        SEL_IMB  = 3'd6,
        SEL_RSV  = 3'd7
    } sel_e;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_CTRL  = 3'd2;
    localparam logic [2:0] OFS_HWRST = 3'd7;

    localparam logic [7:0] CMD_RESET = 8'h80;
    localparam logic [7:0] CMD_SWAP  = 8'h40;
    localparam logic [7:0] CMD_NORM  = 8'h00;

    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
        logic aempty;
    } fifo_flags_t;

    function automatic logic near_full(logic [15:0] cnt, logic [15:0] margin, logic [15:0] depth);
        return (cnt + margin) >= depth;
    endfunction

    function automatic logic near_empty(logic [15:0] cnt, logic [15:0] level);
        return cnt <= level;
    endfunction

    function automatic logic sel_valid(logic [2:0] code);
        return (code != 3'd0) && (code != 3'd7);
    endfunction

endpackage

// File: rtl/fmb_fifo.sv
module fmb_fifo #(
    parameter int W  = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [AW:0]   count
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && (count != (AW+1)'(DEPTH));
    assign do_pop  = pop  && (count != '0);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fmb_status.sv
module fmb_status
    import fmb_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic [AW:0]  in_cnt,
    input  logic [AW:0]  out_cnt,
    input  logic [7:0]   thr,
    input  logic [7:0]   bdet,
    input  logic [7:0]   in_head,
    input  logic         imb_full,
    input  logic         omb_full,
    input  logic         mr,
    input  logic         swap,
    input  logic [6:0]   mask,
    input  logic         gie,
    output logic [7:0]   host_view,
    output logic [7:0]   local_view,
    output logic         irq
);
    localparam int DEPTH = 1 << AW;

    fifo_flags_t fin, fout;
    logic [7:0]  host_raw;

    always_comb begin
        fin.full    = in_cnt  == (AW+1)'(DEPTH);
        fin.empty   = in_cnt  == '0;
        fin.afull   = near_full(16'(in_cnt), 16'(thr[7:4]), 16'(DEPTH));
        fin.aempty  = near_empty(16'(in_cnt), 16'(thr[3:0]));
        fout.full   = out_cnt == (AW+1)'(DEPTH);
        fout.empty  = out_cnt == '0;
        fout.afull  = near_full(16'(out_cnt), 16'(thr[7:4]), 16'(DEPTH));
        fout.aempty = near_empty(16'(out_cnt), 16'(thr[3:0]));
    end

    assign host_raw   = {mr, fout.full, fin.empty, fout.afull, fin.aempty, imb_full,
                         (!fin.empty && (in_head == bdet)), 1'b0};
    assign local_view = {1'b0, fin.full, fout.empty, fin.afull, fout.aempty, omb_full,
                         2'b00};
    assign host_view  = swap ? {mr, local_view[6:0]} : host_raw;
    assign irq        = gie && (mr || ((host_raw[6:0] & mask) != 7'd0));
endmodule

// File: rtl/fifo_mbox_bridge.sv
module fifo_mbox_bridge
    import fmb_pkg::*;
#(
    parameter int DEPTH_LOG2 = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       h_cs,
    input  logic       h_wr,
    input  logic       h_rd,
    input  logic [2:0] h_addr,
    input  logic [7:0] h_wdata,
    output logic [7:0] h_rdata,
    output logic       h_irq,
    input  logic       l_push,
    input  logic [7:0] l_wdata,
    input  logic       l_pop,
    output logic [7:0] l_rdata,
    input  logic       l_mb_wr,
    input  logic [7:0] l_mb_wdata,
    input  logic       l_mb_rd,
    output logic [7:0] l_mb_rdata,
    input  logic       l_gie_wr,
    input  logic       l_gie_val,
    output logic [7:0] l_status
);
    localparam int CW = DEPTH_LOG2 + 1;

    logic       armed, mr, swap, gie, imb_full;
    sel_e       sel;
    logic [7:0] mask, bdet, thr, omb, imb;

    logic wr_data, rd_data, ctrl_wr, ctrl_rd;
    logic ptr_wr, reg_wr, reg_rd, stat_rd;
    logic hw_rst, soft_rst, fifo_clr, omb_wr;

    logic [CW-1:0] in_cnt, out_cnt;
    logic [7:0]    in_head, out_head, host_view;

    assign wr_data  = h_cs && h_wr && (h_addr == OFS_DATA);
    assign rd_data  = h_cs && h_rd && (h_addr == OFS_DATA);
    assign ctrl_wr  = h_cs && h_wr && (h_addr == OFS_CTRL);
    assign ctrl_rd  = h_cs && h_rd && (h_addr == OFS_CTRL);
    assign ptr_wr   = ctrl_wr && !armed;
    assign reg_wr   = ctrl_wr && armed;
    assign reg_rd   = ctrl_rd && armed;
    assign stat_rd  = ctrl_rd && !armed;
    assign hw_rst   = rst || (h_cs && h_wr && (h_addr == OFS_HWRST));
    assign soft_rst = reg_wr && (sel == SEL_CMD) && (h_wdata == CMD_RESET);
    assign fifo_clr = hw_rst || soft_rst;
    assign omb_wr   = reg_wr && (sel == SEL_OMB);

    fmb_fifo #(.W(8), .AW(DEPTH_LOG2)) u_out (
        .clk(clk), .clr(fifo_clr), .push(wr_data), .pop(l_pop),
        .din(h_wdata), .head(out_head), .count(out_cnt)
    );

    fmb_fifo #(.W(8), .AW(DEPTH_LOG2)) u_in (
        .clk(clk), .clr(fifo_clr), .push(l_push), .pop(rd_data),
        .din(l_wdata), .head(in_head), .count(in_cnt)
    );

    fmb_status #(.AW(DEPTH_LOG2)) u_stat (
        .in_cnt(in_cnt), .out_cnt(out_cnt), .thr(thr), .bdet(bdet),
        .in_head(in_head), .imb_full(imb_full), .omb_full(omb != 8'h00),
        .mr(mr), .swap(swap), .mask(mask[6:0]), .gie(gie),
        .host_view(host_view), .local_view(l_status), .irq(h_irq)
    );

    always_ff @(posedge clk) begin
        if (hw_rst) begin
            armed    <= 1'b0;
            sel      <= SEL_NONE;
            mr       <= 1'b1;
            swap     <= 1'b0;
            gie      <= 1'b0;
            mask     <= 8'h00;
            bdet     <= 8'h00;
            thr      <= 8'h00;
            omb      <= 8'h00;
            imb      <= 8'h00;
            imb_full <= 1'b0;
        end else begin
            if (ptr_wr && sel_valid(h_wdata[2:0])) begin
                armed <= 1'b1;
                sel   <= sel_e'(h_wdata[2:0]);
            end
            if (reg_wr || reg_rd) armed <= 1'b0;
            if (stat_rd) mr <= 1'b0;
            if (l_mb_rd) omb <= 8'h00;
            if (reg_rd && (sel == SEL_IMB)) imb_full <= 1'b0;
            if (l_mb_wr) begin
                imb      <= l_mb_wdata;
                imb_full <= 1'b1;
            end
            if (reg_wr) begin
                case (sel)
                    SEL_MASK: mask <= h_wdata;
                    SEL_BDET: bdet <= h_wdata;
                    SEL_THR:  thr  <= h_wdata;
                    SEL_OMB:  omb  <= h_wdata;
                    SEL_CMD: begin
                        if (h_wdata == CMD_RESET) begin
                            mr       <= 1'b1;
                            omb      <= 8'h00;
                            imb      <= 8'h00;
                            imb_full <= 1'b0;
                        end else if (h_wdata == CMD_SWAP) begin
                            swap <= 1'b1;
                        end else if (h_wdata == CMD_NORM) begin
                            swap <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (l_gie_wr) gie <= l_gie_val;
        end
    end

    always_comb begin
        h_rdata = 8'h00;
        if (rd_data) begin
            h_rdata = (in_cnt != '0) ? in_head : 8'h00;
        end else if (stat_rd) begin
            h_rdata = host_view;
        end else if (reg_rd) begin
            case (sel)
                SEL_CMD:  h_rdata = {1'b0, swap, 6'b0};
                SEL_MASK: h_rdata = mask;
                SEL_BDET: h_rdata = bdet;
                SEL_OMB:  h_rdata = omb;
                SEL_THR:  h_rdata = thr;
                SEL_IMB:  h_rdata = imb;
                default:  h_rdata = 8'h00;
            endcase
        end
    end

    assign l_rdata    = (out_cnt != '0) ? out_head : 8'h00;
    assign l_mb_rdata = omb;
endmodule

// File: rtl/fmb_checker.sv
module fmb_checker #(
    parameter int AW = 9
) (
    input logic        clk,
    input logic        rst,
    input logic        h_cs,
    input logic        h_wr,
    input logic        h_rd,
    input logic [2:0]  h_addr,
    input logic        l_pop,
    input logic        l_mb_rd,
    input logic        armed,
    input logic        mr,
    input logic        gie,
    input logic        h_irq,
    input logic [AW:0] out_cnt,
    input logic [7:0]  omb,
    input logic        omb_wr
);
    localparam int DEPTH = 1 << AW;

    // R6: a plain status read leaves the reset-event bit cleared
    assert_mr_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (h_cs && h_rd && h_addr == 3'd2 && !armed) |=> !mr);

    // R12: no interrupt without the global enable
    assert_irq_gated_R12: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !h_irq);

    // R4: selector is consumed by exactly one control access
    assert_ptr_oneshot_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && h_cs && (h_rd || h_wr) && h_addr == 3'd2) |=> !armed);

    // R3: a write into a full outbound FIFO does not change its count
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (out_cnt == (AW+1)'(DEPTH) && h_cs && h_wr && h_addr == 3'd0 && !l_pop)
        |=> (out_cnt == $past(out_cnt)));

    // R2: count bounded by depth
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        out_cnt <= (AW+1)'(DEPTH));

    // R9: consuming the outbound mailbox empties it
    assert_omb_consumed_R9: assert property (@(posedge clk) disable iff (rst)
        (l_mb_rd && !omb_wr) |=> (omb == 8'h00));
endmodule

bind fifo_mbox_bridge fmb_checker #(.AW(DEPTH_LOG2)) u_chk (
    .clk(clk), .rst(rst), .h_cs(h_cs), .h_wr(h_wr), .h_rd(h_rd),
    .h_addr(h_addr), .l_pop(l_pop), .l_mb_rd(l_mb_rd), .armed(armed),
    .mr(mr), .gie(gie), .h_irq(h_irq), .out_cnt(out_cnt), .omb(omb),
    .omb_wr(omb_wr)
);

// File: tb/sim_fifo_mbox_bridge.sv
`timescale 1ns/1ps
module sim_fifo_mbox_bridge;
    localparam int AW = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_cs = 0, h_wr = 0, h_rd = 0;
    logic [2:0] h_addr = 0;
    logic [7:0] h_wdata = 0;
    logic [7:0] h_rdata;
    logic       h_irq;
    logic       l_push = 0, l_pop = 0, l_mb_wr = 0, l_mb_rd = 0;
    logic       l_gie_wr = 0, l_gie_val = 0;
    logic [7:0] l_wdata = 0, l_mb_wdata = 0;
    logic [7:0] l_rdata, l_mb_rdata, l_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] hq_val[$];
    string      hq_tag[$];
    logic [7:0] lq_val[$];
    string      lq_tag[$];

    always #5 clk = ~clk;

    fifo_mbox_bridge #(.DEPTH_LOG2(AW)) u0 (
        .clk(clk), .rst(rst), .h_cs(h_cs), .h_wr(h_wr), .h_rd(h_rd),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
        .l_push(l_push), .l_wdata(l_wdata), .l_pop(l_pop), .l_rdata(l_rdata),
        .l_mb_wr(l_mb_wr), .l_mb_wdata(l_mb_wdata), .l_mb_rd(l_mb_rd),
        .l_mb_rdata(l_mb_rdata), .l_gie_wr(l_gie_wr), .l_gie_val(l_gie_val),
        .l_status(l_status)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: compare design results against queued expectations
    always @(negedge clk) begin
        if (h_cs && h_rd) begin
            if (hq_val.size() == 0) chk("R2 unexpected host read", 8'h00, 8'h01);
            else chk(hq_tag.pop_front(), h_rdata, hq_val.pop_front());
        end
        if (l_pop) begin
            if (lq_val.size() == 0) chk("R2 unexpected local pop", 8'h00, 8'h01);
            else chk(lq_tag.pop_front(), l_rdata, lq_val.pop_front());
        end
    end

    task automatic hacc(bit wr, logic [2:0] a, logic [7:0] d);
        @(posedge clk); #1;
        h_cs = 1; h_wr = wr; h_rd = !wr; h_addr = a; h_wdata = d;
        @(posedge clk); #1;
        h_cs = 0; h_wr = 0; h_rd = 0;
    endtask

    task automatic hread(logic [2:0] a, logic [7:0] exp, string tag);
        hq_val.push_back(exp); hq_tag.push_back(tag);
        hacc(0, a, 8'h00);
    endtask

    task automatic regw(logic [2:0] s, logic [7:0] d);
        hacc(1, 3'd2, {5'd0, s});
        hacc(1, 3'd2, d);
    endtask

    task automatic regr(logic [2:0] s, logic [7:0] exp, string tag);
        hacc(1, 3'd2, {5'd0, s});
        hread(3'd2, exp, tag);
    endtask

    task automatic lpush(logic [7:0] d);
        @(posedge clk); #1; l_push = 1; l_wdata = d;
        @(posedge clk); #1; l_push = 0;
    endtask

    task automatic lpop(logic [7:0] exp, string tag);
        lq_val.push_back(exp); lq_tag.push_back(tag);
        @(posedge clk); #1; l_pop = 1;
        @(posedge clk); #1; l_pop = 0;
    endtask

    task automatic lmbw(logic [7:0] d);
        @(posedge clk); #1; l_mb_wr = 1; l_mb_wdata = d;
        @(posedge clk); #1; l_mb_wr = 0;
    endtask

    task automatic lmbr();
        @(posedge clk); #1; l_mb_rd = 1;
        @(posedge clk); #1; l_mb_rd = 0;
    endtask

    task automatic lgie(bit v);
        @(posedge clk); #1; l_gie_wr = 1; l_gie_val = v;
        @(posedge clk); #1; l_gie_wr = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // reset state
        chk("R1 local status after reset", l_status, 8'h28);
        chk("R1 irq after reset", {7'd0, h_irq}, 8'h00);
        hread(3'd2, 8'hA8, "R1 host status after reset");
        hread(3'd2, 8'h28, "R6 reset bit cleared by read");

        // register access through selector
        regw(3'd2, 8'h24);
        regr(3'd2, 8'h24, "R5 mask readback");
        hread(3'd2, 8'h28, "R4 selector consumed, status again");
        chk("R12 irq low without enable", {7'd0, h_irq}, 8'h00);
        lgie(1);
        chk("R12 irq with enable and masked empty", {7'd0, h_irq}, 8'h01);

        // offset 7 reset
        hacc(1, 3'd7, 8'h00);
        chk("R13 irq cleared by offset-7 reset", {7'd0, h_irq}, 8'h00);
        regr(3'd2, 8'h00, "R13 mask cleared");
        hread(3'd2, 8'hA8, "R13 reset bit set");

        // data path in, byte detect
        regw(3'd3, 8'h11);
        regr(3'd3, 8'h11, "R5 byte-compare readback");
        lpush(8'h11); lpush(8'h22); lpush(8'h33);
        hread(3'd2, 8'h02, "R10 byte detected at head");
        hread(3'd0, 8'h11, "R2 inbound order 1");
        hread(3'd2, 8'h00, "R10 no match after pop");
        hread(3'd0, 8'h22, "R2 inbound order 2");
        hread(3'd0, 8'h33, "R2 inbound order 3");
        hread(3'd0, 8'h00, "R3 empty inbound reads zero");
        hread(3'd2, 8'h28, "R3 inbound empty again");

        // outbound fill past capacity
        for (int i = 0; i < 9; i++) hacc(1, 3'd0, 8'hA0 + 8'(i));
        hread(3'd2, 8'h78, "R3 outbound full");
        for (int i = 0; i < 8; i++) lpop(8'hA0 + 8'(i), "R2 outbound order");
        chk("R3 ninth write dropped", l_status, 8'h28);

        // thresholds
        regw(3'd5, 8'h23);
        regr(3'd5, 8'h23, "R5 threshold readback");
        for (int i = 0; i < 5; i++) hacc(1, 3'd0, 8'h50 + 8'(i));
        hread(3'd2, 8'h28, "R7 below almost-full margin");
        hacc(1, 3'd0, 8'h55);
        hread(3'd2, 8'h38, "R7 almost-full reached");
        lpush(8'h01); lpush(8'h02); lpush(8'h03);
        hread(3'd2, 8'h18, "R7 almost-empty at level");
        lpush(8'h04);
        hread(3'd2, 8'h10, "R7 almost-empty above level");

        // command reset
        regw(3'd1, 8'h80);
        hread(3'd2, 8'hA8, "R11 command reset empties fifos");
        hread(3'd0, 8'h00, "R11 inbound emptied");
        chk("R11 outbound emptied", l_status, 8'h28);

        // inbound mailbox
        lmbw(8'h5C);
        hread(3'd2, 8'h2C, "R8 inbound mailbox full");
        regr(3'd6, 8'h5C, "R8 inbound mailbox value");
        hread(3'd2, 8'h28, "R8 inbound mailbox cleared");

        // outbound mailbox
        regw(3'd4, 8'h77);
        chk("R9 local mailbox view", l_mb_rdata, 8'h77);
        chk("R9 local mailbox-full bit", l_status, 8'h2C);
        regr(3'd4, 8'h77, "R9 outbound readback");
        lmbr();
        regr(3'd4, 8'h00, "R9 readback zero after consume");

        // swapped status view
        regw(3'd1, 8'h40);
        hacc(1, 3'd0, 8'h99);
        hread(3'd2, 8'h08, "R11 swapped view");
        regr(3'd1, 8'h40, "R11 command readback");
        regw(3'd1, 8'h00);
        hread(3'd2, 8'h28, "R11 normal view restored");
        lpop(8'h99, "R2 outbound single");

        // interrupt masking
        regw(3'd2, 8'h04);
        lgie(1);
        chk("R12 irq low, masked source idle", {7'd0, h_irq}, 8'h00);
        lmbw(8'h10);
        chk("R12 irq from mailbox", {7'd0, h_irq}, 8'h01);
        regr(3'd6, 8'h10, "R8 second mailbox value");
        chk("R12 irq drops after mailbox read", {7'd0, h_irq}, 8'h00);
        regw(3'd1, 8'h80);
        chk("R12 reset bit unmaskable", {7'd0, h_irq}, 8'h01);
        hread(3'd2, 8'hA8, "R6 reset bit after command");
        chk("R12 irq clears with reset bit", {7'd0, h_irq}, 8'h00);

        // invalid selector codes
        hacc(1, 3'd2, 8'h00);
        hread(3'd2, 8'h28, "R4 code 0 selects nothing");
        hacc(1, 3'd2, 8'h07);
        hread(3'd2, 8'h28, "R4 code 7 selects nothing");

        repeat (3) @(posedge clk);
        #1;
        chk("R2 all host reads compared", 8'(hq_val.size()), 8'h00);
        chk("R2 all local pops compared", 8'(lq_val.size()), 8'h00);
        done = 1;
        summary();
    end
endmodule